// File: doc/BRIEF.md
# Multi-Mode 64-Bit Block Cipher Mode Controller

This block wraps a 64-bit block cipher engine and turns it into a streaming encryptor or decryptor with a selectable chaining mode: electronic codebook, cipher block chaining, cipher feedback or output feedback. Segments arrive on a valid/ready input stream and results leave on a valid/ready output stream. The controller keeps the 64-bit feedback register, which holds the IV at message start and the chaining value after that. It builds the word handed to the engine, drives the engine's start/done handshake and combines the engine result with the held input segment. In the two feedback modes the segment may be a full 64-bit block, a byte, or a single bit. In a narrow segment the data sits in the low bits of the 64-bit data ports.

Configuration is captured when the IV is loaded, which is allowed only between messages. The captured fields are the mode, the direction, the segment size, the algorithm, and whether the message produces an authentication code. In authentication-code mode the per-segment results are suppressed and one word is emitted at the end of the message. The engine supplied with the block is a keyed stand-in Feistel permutation. The algorithm field perturbs its round keys, so each algorithm code gives a distinct permutation.

The control state machine has three states. `ST_IDLE` accepts a segment (transition *accept*, to `ST_CORE`) or an IV load. `ST_CORE` waits for the engine. On *core_done* it goes to `ST_EMIT` when a result must be shown, and back to `ST_IDLE` (transition *absorb*) when an authentication-code message is not yet at its last segment. `ST_EMIT` holds the result until *out_ready* (transition *drain*, to `ST_IDLE`).

Top module: `blkmode_ctrl`

## Requirements
- R1: With mode code 0 (codebook), each 64-bit input word gives out_data = E(in) when encrypting and D(in) when decrypting. E and D are the stand-in cipher under `key` and the captured algorithm code.
- R2: With mode code 1 (block chaining), encryption emits C = E(P xor F) and decryption emits P = D(C) xor F. F starts as the IV and becomes the ciphertext word C after each block.
- R3: With mode code 2 (cipher feedback) and segment code 0/1/2 (64/8/1 bits), the register F is encrypted. The top s bits of the result are XORed with the low s bits of in_data to give the low s bits of out_data, and the upper output bits are zero. F then shifts left by s, and the ciphertext segment enters on the right.
- R4: With mode code 3 (output feedback), the steps are the same as R3, except that the top s bits of the engine output enter F instead of the ciphertext. Decryption is therefore the same operation as encryption.
- R5: In modes 0 and 1 the segment code is ignored and full 64-bit blocks are processed. Segment code 3 also means 64 bits.
- R6: With cfg_mac set at IV load, no output is produced for non-final segments. After the segment with in_last, exactly one word with out_last = 1 is emitted, equal to F after that segment. In mode 0, F takes the engine output of every block.
- R7: The algorithm code captured at IV load selects the engine permutation. Different codes give different results for the same key and data.
- R8: iv_load takes effect (loading F from iv_data and capturing cfg_*) only in ST_IDLE between messages. A pulse while a message is open is ignored.
- R9: in_ready is low in the cycle after a segment is accepted, and it stays low while the engine runs or a result waits.
- R10: While out_valid is high and out_ready is low, out_valid, out_data and out_last stay unchanged.
- R11: After reset, in_ready is high and out_valid is low. The mode is codebook encryption with F = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key | input | 64 | Cipher key, held stable during a message |
| cfg_mode | input | 2 | 0 codebook, 1 block chaining, 2 cipher feedback, 3 output feedback |
| cfg_dec | input | 1 | 1 selects decryption |
| cfg_seg | input | 2 | Feedback segment: 0 = 64, 1 = 8, 2 = 1 bit |
| cfg_alg | input | 2 | Algorithm code |
| cfg_mac | input | 1 | Produce only a final authentication word |
| iv_load | input | 1 | Load F and capture cfg_* (message boundary only) |
| iv_data | input | 64 | IV value |
| in_valid | input | 1 | Input segment valid |
| in_ready | output | 1 | Input segment accepted when high with in_valid |
| in_data | input | 64 | Input segment, low-aligned |
| in_last | input | 1 | Marks the final segment of a message |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result accepted when high with out_valid |
| out_data | output | 64 | Result segment, or authentication word |
| out_last | output | 1 | Result belongs to the final segment |

## Verification
The assertions assume that the input stream only raises iv_load while in_ready is high, and that key stays stable for the whole of a message. The assertions also assume that the environment holds an offered segment until it is accepted. The stimulus drives inputs on the falling edge, keeps every segment valid until in_ready is seen high, and pulses iv_load only after in_ready is high. One test deliberately pulses iv_load in the middle of an open message, to exercise the rule that the pulse is ignored. Output backpressure is drawn at random on every falling edge, so results are often held across several cycles.

// File: rtl/bm_pkg.sv
package bm_pkg;

    typedef enum logic [1:0] {
        MD_ECB = 2'd0,
        MD_CBC = 2'd1,
        MD_CFB = 2'd2,
        MD_OFB = 2'd3
    } bm_mode_e;

    typedef enum logic [1:0] {
        SG_64 = 2'd0,
        SG_8  = 2'd1,
        SG_1  = 2'd2
    } bm_seg_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CORE = 2'd1,
        ST_EMIT = 2'd2
    } bm_state_e;

endpackage

// File: rtl/bm_cipher_core.sv
// Stand-in keyed Feistel permutation, one round per cycle.
module bm_cipher_core #(
    parameter int BLK_W  = 64,
    parameter int ROUNDS = 6,
    parameter int ALG_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dec,
    input  logic [ALG_W-1:0] alg,
    input  logic [BLK_W-1:0] key,
    input  logic [BLK_W-1:0] din,
    output logic             done,
    output logic [BLK_W-1:0] dout
);
    localparam int H     = BLK_W / 2;
    localparam int CNT_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;

    logic [H-1:0]     left_q, right_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q, dec_q;
    logic [CNT_W-1:0] idx;
    logic [H-1:0]     rkey;

    function automatic logic [H-1:0] rnd_f(logic [H-1:0] x, logic [H-1:0] k);
        return ({x[H-6:0], x[H-1:H-5]} + k) ^ {x[7:0], x[H-1:8]};
    endfunction

    always_comb begin
        idx  = dec_q ? (CNT_W'(ROUNDS - 1) - cnt_q) : cnt_q;
        rkey = (idx[0] ? key[H-1:0] : key[BLK_W-1:H])
             ^ {alg, {(H-ALG_W){1'b0}}}
             ^ H'(idx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q  <= '0;
            right_q <= '0;
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            dec_q   <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                left_q  <= din[BLK_W-1:H];
                right_q <= din[H-1:0];
                cnt_q   <= '0;
                busy_q  <= 1'b1;
                dec_q   <= dec;
            end else if (busy_q) begin
                if (!dec_q) begin
                    left_q  <= right_q;
                    right_q <= left_q ^ rnd_f(right_q, rkey);
                end else begin
                    left_q  <= right_q ^ rnd_f(left_q, rkey);
                    right_q <= left_q;
                end
                if (cnt_q == CNT_W'(ROUNDS - 1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign dout = {left_q, right_q};
endmodule

// File: rtl/bm_seg_unit.sv
// Mode datapath: engine input word, output segment and next feedback value.
module bm_seg_unit
    import bm_pkg::*;
#(
    parameter int BLK_W = 64,
    parameter int SEG_B = 8
) (
    input  bm_mode_e         mode,
    input  logic             dec,
    input  bm_seg_e          seg,
    input  logic [BLK_W-1:0] fb,
    input  logic [BLK_W-1:0] din,
    input  logic [BLK_W-1:0] core_dout,
    output logic [BLK_W-1:0] core_din,
    output logic             core_dec,
    output logic [BLK_W-1:0] out_seg,
    output logic [BLK_W-1:0] fb_next
);
    logic [BLK_W-1:0] mask, kstream, din_m, fb_in;

    always_comb begin
        unique case (seg)
            SG_8: begin
                mask    = {{(BLK_W-SEG_B){1'b0}}, {SEG_B{1'b1}}};
                kstream = {{(BLK_W-SEG_B){1'b0}}, core_dout[BLK_W-1 -: SEG_B]};
            end
            SG_1: begin
                mask    = {{(BLK_W-1){1'b0}}, 1'b1};
                kstream = {{(BLK_W-1){1'b0}}, core_dout[BLK_W-1]};
            end
            default: begin
                mask    = '1;
                kstream = core_dout;
            end
        endcase
        din_m = din & mask;

        core_din = fb;
        core_dec = 1'b0;
        out_seg  = din_m ^ kstream;
        fb_in    = '0;
        fb_next  = fb;

        unique case (mode)
            MD_ECB: begin
                core_din = din;
                core_dec = dec;
                out_seg  = core_dout;
                fb_next  = core_dout;
            end
            MD_CBC: begin
                core_din = dec ? din : (din ^ fb);
                core_dec = dec;
                out_seg  = dec ? (core_dout ^ fb) : core_dout;
                fb_next  = dec ? din : core_dout;
            end
            MD_CFB, MD_OFB: begin
                if (mode == MD_OFB) fb_in = kstream;
                else                fb_in = dec ? din_m : out_seg;
                unique case (seg)
                    SG_8:    fb_next = {fb[BLK_W-SEG_B-1:0], fb_in[SEG_B-1:0]};
                    SG_1:    fb_next = {fb[BLK_W-2:0], fb_in[0]};
                    default: fb_next = fb_in;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/blkmode_ctrl.sv
module blkmode_ctrl
    import bm_pkg::*;
#(
    parameter int BLK_W  = 64,
    parameter int ROUNDS = 6,
    parameter int ALG_W  = 2,
    parameter int SEG_B  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BLK_W-1:0] key,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_dec,
    input  logic [1:0]       cfg_seg,
    input  logic [ALG_W-1:0] cfg_alg,
    input  logic             cfg_mac,
    input  logic             iv_load,
    input  logic [BLK_W-1:0] iv_data,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [BLK_W-1:0] in_data,
    input  logic             in_last,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [BLK_W-1:0] out_data,
    output logic             out_last
);
    bm_state_e        state_q, state_d;
    bm_mode_e         mode_q;
    bm_seg_e          seg_q, seg_cfg;
    logic             dec_q, mac_q, last_q, msg_active_q, start_q;
    logic [ALG_W-1:0] alg_q;
    logic [BLK_W-1:0] fb_reg, din_q;
    logic [BLK_W-1:0] core_din, core_dout, out_seg, fb_next;
    logic             core_dec, core_done;
    logic             accept, iv_take, need_out, idle;

    assign idle     = (state_q == ST_IDLE);
    assign iv_take  = iv_load && idle && !msg_active_q;
    assign in_ready = idle && !iv_take;
    assign accept   = in_valid && in_ready;
    assign need_out = !mac_q || last_q;
    assign out_valid = (state_q == ST_EMIT);

    always_comb begin
        unique case (cfg_seg)
            2'd1:    seg_cfg = SG_8;
            2'd2:    seg_cfg = SG_1;
            default: seg_cfg = SG_64;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)     state_d = ST_CORE;
            ST_CORE: if (core_done)  state_d = need_out ? ST_EMIT : ST_IDLE;
            ST_EMIT: if (out_ready)  state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q       <= MD_ECB;
            seg_q        <= SG_64;
            dec_q        <= 1'b0;
            mac_q        <= 1'b0;
            alg_q        <= '0;
            fb_reg       <= '0;
            din_q        <= '0;
            last_q       <= 1'b0;
            msg_active_q <= 1'b0;
            start_q      <= 1'b0;
            out_data     <= '0;
            out_last     <= 1'b0;
        end else begin
            start_q <= accept;
            if (iv_take) begin
                fb_reg <= iv_data;
                mode_q <= bm_mode_e'(cfg_mode);
                dec_q  <= cfg_dec;
                mac_q  <= cfg_mac;
                alg_q  <= cfg_alg;
                seg_q  <= (cfg_mode == MD_CFB || cfg_mode == MD_OFB) ? seg_cfg : SG_64;
            end
            if (accept) begin
                din_q        <= in_data;
                last_q       <= in_last;
                msg_active_q <= !in_last;
            end
            if (state_q == ST_CORE && core_done) begin
                fb_reg   <= fb_next;
                out_data <= mac_q ? fb_next : out_seg;
                out_last <= last_q;
            end
        end
    end

    bm_seg_unit #(.BLK_W(BLK_W), .SEG_B(SEG_B)) u_seg (
        .mode      (mode_q),
        .dec       (dec_q),
        .seg       (seg_q),
        .fb        (fb_reg),
        .din       (din_q),
        .core_dout (core_dout),
        .core_din  (core_din),
        .core_dec  (core_dec),
        .out_seg   (out_seg),
        .fb_next   (fb_next)
    );

    bm_cipher_core #(.BLK_W(BLK_W), .ROUNDS(ROUNDS), .ALG_W(ALG_W)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_q),
        .dec   (core_dec),
        .alg   (alg_q),
        .key   (key),
        .din   (core_din),
        .done  (core_done),
        .dout  (core_dout)
    );
endmodule

// File: rtl/bm_chk.sv
module bm_chk #(
    parameter int BLK_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [BLK_W-1:0] out_data,
    input logic             out_last,
    input logic             iv_load,
    input logic             idle,
    input logic             msg_active_q,
    input logic             mac_q,
    input logic [BLK_W-1:0] fb_reg
);
    p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    p_no_take_while_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    p_mac_final_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mac_q) |-> out_last);

    p_iv_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (iv_load && idle && msg_active_q) |=> $stable(fb_reg));

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r11: assert (!out_valid);
        end
    end
endmodule

bind blkmode_ctrl bm_chk #(.BLK_W(BLK_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .out_last     (out_last),
    .iv_load      (iv_load),
    .idle         (idle),
    .msg_active_q (msg_active_q),
    .mac_q        (mac_q),
    .fb_reg       (fb_reg)
);

// File: tb/blkmode_ctrl_tb.sv
module blkmode_ctrl_tb;
    localparam int ROUNDS = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] key = 64'h0F1E_2D3C_4B5A_6978;
    logic [1:0]  cfg_mode = 2'd0, cfg_seg = 2'd0, cfg_alg = 2'd0;
    logic        cfg_dec = 1'b0, cfg_mac = 1'b0;
    logic        iv_load = 1'b0;
    logic [63:0] iv_data = '0;
    logic        in_valid = 1'b0, in_last = 1'b0;
    logic [63:0] in_data = '0;
    logic        in_ready, out_valid, out_last;
    logic        out_ready = 1'b0;
    logic [63:0] out_data;

    always #10 clk = ~clk;

    blkmode_ctrl #(.ROUNDS(ROUNDS)) u_dut (
        .clk(clk), .rst_n(rst_n), .key(key),
        .cfg_mode(cfg_mode), .cfg_dec(cfg_dec), .cfg_seg(cfg_seg),
        .cfg_alg(cfg_alg), .cfg_mac(cfg_mac),
        .iv_load(iv_load), .iv_data(iv_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );

    int nvec = 0, nfail = 0;
    logic [64:0] exp_q[$];
    string       tag_q[$];
    string       cur_tag = "R11";
    logic [63:0] pt[16], ct[16];
    logic [63:0] res_last;

    // bench model state
    logic [63:0] m_fb;
    int          m_mode, m_seg;
    bit          m_dec, m_mac;
    logic [1:0]  m_alg;
    bit          mon_on = 1'b0;

    function automatic logic [31:0] f_rnd(logic [31:0] x, logic [31:0] k);
        return ({x[26:0], x[31:27]} + k) ^ {x[7:0], x[31:8]};
    endfunction

    function automatic logic [31:0] f_rk(int idx, logic [1:0] alg);
        logic [31:0] h;
        h = idx[0] ? key[31:0] : key[63:32];
        return h ^ {alg, 30'd0} ^ 32'(idx);
    endfunction

    function automatic logic [63:0] f_cipher(logic [63:0] x, bit dec, logic [1:0] alg);
        logic [31:0] l, r, t;
        l = x[63:32];
        r = x[31:0];
        for (int i = 0; i < ROUNDS; i++) begin
            int idx = dec ? ROUNDS - 1 - i : i;
            if (!dec) begin t = r; r = l ^ f_rnd(r, f_rk(idx, alg)); l = t; end
            else      begin t = l; l = r ^ f_rnd(t, f_rk(idx, alg)); r = t; end
        end
        return {l, r};
    endfunction

    // model one segment: returns output, updates m_fb
    function automatic logic [63:0] f_step(logic [63:0] din);
        logic [63:0] o, mask, ks, dm, fin, res;
        mask = (m_seg == 64) ? '1 : ((64'd1 << m_seg) - 1);
        o = 64'd0;
        case (m_mode)
            0: begin o = f_cipher(din, m_dec, m_alg); res = o; m_fb = o; end
            1: begin
                if (m_dec) begin o = f_cipher(din, 1'b1, m_alg) ^ m_fb; m_fb = din; end
                else begin o = f_cipher(din ^ m_fb, 1'b0, m_alg); m_fb = o; end
                res = o;
            end
            default: begin
                o  = f_cipher(m_fb, 1'b0, m_alg);
                ks = o >> (64 - m_seg);
                dm = din & mask;
                res = dm ^ ks;
                if (m_mode == 3) fin = ks;
                else             fin = m_dec ? dm : res;
                m_fb = (m_seg == 64) ? fin : ((m_fb << m_seg) | fin);
            end
        endcase
        return res;
    endfunction

    task automatic load_cfg(int mode, bit dec, int segc, bit mac, logic [1:0] alg,
                            logic [63:0] iv, string tag);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        cfg_mode = 2'(mode); cfg_dec = dec; cfg_seg = 2'(segc);
        cfg_mac = mac; cfg_alg = alg; iv_data = iv; iv_load = 1'b1;
        @(posedge clk);
        @(negedge clk);
        iv_load = 1'b0;
        cur_tag = tag;
        m_fb = iv; m_mode = mode; m_dec = dec; m_mac = mac; m_alg = alg;
        m_seg = (mode < 2) ? 64 : (segc == 1 ? 8 : (segc == 2 ? 1 : 64));
    endtask

    task automatic send(logic [63:0] din, bit last);
        logic [63:0] r;
        r = f_step(din);
        res_last = r;
        if (!m_mac) begin exp_q.push_back({last, r}); tag_q.push_back(cur_tag); end
        else if (last) begin exp_q.push_back({1'b1, m_fb}); tag_q.push_back(cur_tag); end
        @(negedge clk);
        in_valid = 1'b1; in_data = din; in_last = last;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        nvec++;
        if (in_ready !== 1'b0) begin
            nfail++;
            $display("FAIL R9: in_ready after accept act=%b exp=0", in_ready);
        end
    endtask

    // attempt an IV load in the middle of a message (R8)
    task automatic poke_iv();
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        cfg_mode = 2'd0; cfg_dec = 1'b1; iv_data = 64'hDEAD_BEEF_0BAD_F00D; iv_load = 1'b1;
        @(posedge clk);
        @(negedge clk);
        iv_load = 1'b0;
    endtask

    task automatic run(int mode, bit dec, int segc, bit mac, logic [1:0] alg,
                       logic [63:0] iv, int n, bit use_ct, int mid_iv, string tag);
        load_cfg(mode, dec, segc, mac, alg, iv, tag);
        for (int i = 0; i < n; i++) begin
            send(use_ct ? ct[i] : pt[i], i == n - 1);
            if (!use_ct && !mac) ct[i] = res_last;
            if (i == mid_iv) poke_iv();
        end
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // monitor / scoreboard
    logic        hold_chk = 1'b0;
    logic [64:0] hold_v;
    always @(negedge clk) begin
        if (mon_on) begin
            if (hold_chk) begin
                nvec++;
                if (!out_valid || {out_last, out_data} !== hold_v) begin
                    nfail++;
                    $display("FAIL R10: held output act=%b/%h exp=1/%h", out_valid,
                             {out_last, out_data}, hold_v);
                end
            end
            out_ready = ($urandom_range(0, 3) != 0);
            hold_chk = out_valid && !out_ready;
            hold_v = {out_last, out_data};
            if (out_valid && out_ready) begin
                nvec++;
                if (exp_q.size() == 0) begin
                    nfail++;
                    $display("FAIL %s: unexpected output act=%h exp=none", cur_tag, out_data);
                end else begin
                    logic [64:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if ({out_last, out_data} !== e) begin
                        nfail++;
                        $display("FAIL %s: act=%b/%h exp=%b/%h", t, out_last, out_data, e[64], e[63:0]);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: act=timeout exp=completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) pt[i] = {$urandom, $urandom};
        repeat (3) @(posedge clk);
        @(negedge clk);
        nvec++;
        if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
            nfail++;
            $display("FAIL R11: reset ready/valid act=%b%b exp=10", in_ready, out_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        // R11: default config is codebook encryption, alg 0
        m_fb = '0; m_mode = 0; m_dec = 0; m_mac = 0; m_alg = 2'd0; m_seg = 64; cur_tag = "R11";
        send(pt[0], 1'b1);
        while (exp_q.size() != 0) @(negedge clk);

        run(0, 0, 0, 0, 2'd0, 64'h0, 4, 0, -1, "R1");
        run(0, 1, 0, 0, 2'd0, 64'h0, 4, 1, -1, "R1");
        run(0, 0, 0, 0, 2'd2, 64'h0, 4, 0, -1, "R7");
        run(0, 1, 0, 0, 2'd2, 64'h0, 4, 1, -1, "R7");
        run(1, 0, 0, 0, 2'd1, 64'h1234_5678_9ABC_DEF0, 5, 0, -1, "R2");
        run(1, 1, 0, 0, 2'd1, 64'h1234_5678_9ABC_DEF0, 5, 1, -1, "R2");
        run(2, 0, 0, 0, 2'd0, 64'hA5A5_0000_FFFF_1111, 4, 0, -1, "R3");
        run(2, 1, 0, 0, 2'd0, 64'hA5A5_0000_FFFF_1111, 4, 1, -1, "R3");
        run(2, 0, 1, 0, 2'd3, 64'h0102_0304_0506_0708, 10, 0, -1, "R3");
        run(2, 1, 1, 0, 2'd3, 64'h0102_0304_0506_0708, 10, 1, -1, "R3");
        run(2, 0, 2, 0, 2'd1, 64'hFEDC_BA98_7654_3210, 16, 0, -1, "R3");
        run(2, 1, 2, 0, 2'd1, 64'hFEDC_BA98_7654_3210, 16, 1, -1, "R3");
        run(3, 0, 0, 0, 2'd0, 64'h1111_2222_3333_4444, 4, 0, -1, "R4");
        run(3, 1, 0, 0, 2'd0, 64'h1111_2222_3333_4444, 4, 1, -1, "R4");
        run(3, 0, 1, 0, 2'd2, 64'h5555_6666_7777_8888, 9, 0, -1, "R4");
        run(3, 1, 1, 0, 2'd2, 64'h5555_6666_7777_8888, 9, 1, -1, "R4");
        run(3, 0, 2, 0, 2'd0, 64'h9999_AAAA_BBBB_CCCC, 12, 0, -1, "R4");
        run(3, 1, 2, 0, 2'd0, 64'h9999_AAAA_BBBB_CCCC, 12, 1, -1, "R4");
        // R5: segment code ignored in chaining/codebook; code 3 means 64
        run(1, 0, 1, 0, 2'd0, 64'h0F0F_0F0F_F0F0_F0F0, 3, 0, -1, "R5");
        run(0, 0, 2, 0, 2'd1, 64'h0, 3, 0, -1, "R5");
        run(2, 0, 3, 0, 2'd1, 64'h7777_0000_7777_0000, 3, 0, -1, "R5");
        // R6: authentication word only at the end
        run(1, 0, 0, 1, 2'd0, 64'h0, 6, 0, -1, "R6");
        run(2, 0, 1, 1, 2'd2, 64'h3C3C_3C3C_3C3C_3C3C, 7, 0, -1, "R6");
        run(0, 0, 0, 1, 2'd3, 64'h0, 3, 0, -1, "R6");
        // R8: IV load in mid-message must be ignored
        run(1, 0, 0, 0, 2'd1, 64'h2468_ACE0_1357_9BDF, 4, 0, 1, "R8");
        run(2, 0, 1, 0, 2'd0, 64'hCAFE_0000_BABE_0000, 6, 0, 2, "R8");

        repeat (5) @(negedge clk);
        if (exp_q.size() != 0) begin
            nfail++;
            $display("FAIL %s: outputs missing act=%0d exp=0", cur_tag, exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule